// File: doc/BRIEF.md
# Sliding Reference Window Buffer

This block is the on-chip pixel store that feeds a frame-interpolation datapath one 16x16 macroblock at a time. It keeps two search windows side by side: one cut from the current frame and one from the reference frame. Each window is `MB + 2*H_RANGE` pixels wide and `MB + 2*V_RANGE` rows tall. With `H_RANGE = 48` and `V_RANGE = 24`, each window is 112x64 and a block can be displaced by ±48 columns and ±24 rows. The default parameters use a smaller geometry (±16, ±8, giving 48x32 windows) so that the storage stays small at elaboration. Every pixel word is 32 bits wide and carries three 10-bit colour channels. The block treats that word as opaque.

Each window is spread over `MB` single-write, single-read banks. Bank `i` holds every window column whose index is congruent to `i` modulo `MB`. Any 16 horizontally adjacent pixels therefore come out in one cycle, whatever the alignment, together with a rotation amount for the aligner downstream. Each line has room for `MB` extra columns beyond the window, and the columns are addressed circularly. The external fetch engine writes the next macroblock's `MB`-wide strip into those spare columns while the datapath keeps reading the current window. A step to the next macroblock then only moves a base pointer, so no stored pixel is copied. The step is accepted only once the whole strip of both frames has arrived.

A read names a row inside the block and a signed motion vector. The current-frame window is read displaced by `+mv` and the reference-frame window by `-mv`, both measured from the centred block position.

Top module: `srw_window_buffer`

## Requirements
- R1: After reset, `fill_done_o` and `rd_vld_o` are 0 and the window holds no strips. The first strip written is placed so that, after `WIN_W/MB` fill-and-advance steps, the strips written appear left to right in the order they were written.
- R2: A write with `wr_en_i=1` stores `wr_data_i` at strip column `wr_col_i` (0..MB-1) and row `wr_row_i` (0..WIN_H-1) of the strip just right of the current window. `wr_frame_i` selects the frame: 0 = current, 1 = reference.
- R3: `fill_done_o` is 0 until `2*MB*WIN_H` writes have been taken since reset or since the last accepted advance. It is 1 in the cycle after that last write and stays 1 until the next accepted advance.
- R4: A `mb_adv_i` pulse while `fill_done_o` is 0 is ignored: the window position and the fill count are unchanged.
- R5: A `mb_adv_i` pulse while `fill_done_o` is 1 slides the window right by `MB` columns, so the freshly filled strip becomes its rightmost part. `fill_done_o` is 0 in the following cycle. Column addressing wraps circularly with no data movement.
- R6: A read request with `rd_en_i=1` gives `rd_vld_o=1` exactly one cycle later, and `rd_vld_o=0` follows a cycle without a request. The current data come from window column `H_RANGE+mvx` and row `V_RANGE+rd_row_i+mvy`. The reference data come from column `H_RANGE-mvx` and row `V_RANGE+rd_row_i-mvy`.
- R7: The data buses are in bank order: slice `i` (bits `i*32 +: 32`) holds the pixel whose window column is congruent to `i` modulo MB. `cur_rot_o` and `ref_rot_o` give the start column modulo MB. Logical pixel `j` (0..MB-1, left to right) is in slice `(rot+j) mod MB`.
- R8: Motion vector components are clamped to ±H_RANGE horizontally and ±V_RANGE vertically before they are used.
- R9: Writes and reads in the same cycle do not disturb each other. Until the advance is accepted, reads issued during a refill return the old window.
- R10: A read issued in the same cycle as an accepted advance uses the window as it was before that advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Strip write strobe |
| wr_frame_i | input | 1 | Frame of the write: 0 current, 1 reference |
| wr_col_i | input | log2(MB) | Column inside the new strip |
| wr_row_i | input | log2(WIN_H) | Row of the window |
| wr_data_i | input | PIX_W | Pixel word to store |
| mb_adv_i | input | 1 | Request to move to the next macroblock |
| fill_done_o | output | 1 | Next strip complete in both frames |
| rd_en_i | input | 1 | Read request |
| rd_row_i | input | log2(MB) | Row inside the macroblock |
| rd_mvx_i | input | MVX_W | Signed horizontal motion vector |
| rd_mvy_i | input | MVY_W | Signed vertical motion vector |
| rd_vld_o | output | 1 | Read data valid |
| cur_pix_o | output | MB*PIX_W | Current-frame pixels in bank order |
| ref_pix_o | output | MB*PIX_W | Reference-frame pixels in bank order |
| cur_rot_o | output | log2(MB) | Rotation for the current-frame pixels |
| ref_rot_o | output | log2(MB) | Rotation for the reference-frame pixels |

## Verification
Read data, rotations and `rd_vld_o` are due one cycle after the request edge. `fill_done_o` changes one cycle after the completing write or the accepted advance. The scoreboard records, in each expected item, the cycle in which the request was driven. It fails an item that is not consumed exactly one cycle later. Flag checks are sampled at the falling edge that follows the edge where the change is due. Refill strips run with interleaved reads and an advance that coincides with a read. The window positions used cover the point where the circular column index wraps.

// File: rtl/srw_pkg.sv
package srw_pkg;

    // Which window a write is aimed at.
    typedef enum logic {
        FRAME_CUR = 1'b0,
        FRAME_REF = 1'b1
    } frame_e;

    // Saturate a signed value to +/- lim.
    function automatic int clamp_sym(input int v, input int lim);
        if (v > lim) return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

    // Non-negative remainder.
    function automatic int mod_pos(input int v, input int m);
        int r;
        r = v % m;
        if (r < 0) r = r + m;
        return r;
    endfunction

endpackage

// File: rtl/srw_bank.sv
// One pixel bank: one synchronous write port, one registered read port.
module srw_bank #(
    parameter int PIX_W  = 32,
    parameter int DEPTH  = 128,
    parameter int ADDR_W = 7
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [PIX_W-1:0]  wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [PIX_W-1:0]  rdata_o
);

    logic [PIX_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        if (re_i) begin
            rdata_o <= mem_q[raddr_i];
        end
    end

endmodule

// File: rtl/srw_rd_addr.sv
// Per-bank read addresses for one window. NEGATE selects the
// -mv displacement used for the reference window.
module srw_rd_addr #(
    parameter int MB      = 16,
    parameter int H_RANGE = 16,
    parameter int V_RANGE = 8,
    parameter bit NEGATE  = 1'b0,
    parameter int MVX_W   = 6,
    parameter int MVY_W   = 5,
    parameter int PCOL_W  = 6,
    parameter int ADDR_W  = 7
) (
    input  logic signed [MVX_W-1:0]          mvx_i,
    input  logic signed [MVY_W-1:0]          mvy_i,
    input  logic [$clog2(MB)-1:0]            row_i,
    input  logic [PCOL_W-1:0]                base_i,
    output logic [MB-1:0][ADDR_W-1:0]        addr_o,
    output logic [$clog2(MB)-1:0]            rot_o
);

    localparam int BANK_W = $clog2(MB);
    localparam int WIN_W  = MB + 2 * H_RANGE;
    localparam int WIN_H  = MB + 2 * V_RANGE;
    localparam int CAP    = WIN_W + MB;

    int x0;
    int y;

    always_comb begin
        if (NEGATE) begin
            x0 = H_RANGE - int'(mvx_i);
            y  = V_RANGE + int'(row_i) - int'(mvy_i);
        end else begin
            x0 = H_RANGE + int'(mvx_i);
            y  = V_RANGE + int'(row_i) + int'(mvy_i);
        end
        rot_o = BANK_W'(srw_pkg::mod_pos(x0, MB));
    end

    // Bank b supplies the only column of [x0, x0+MB) congruent to b.
    for (genvar b = 0; b < MB; b++) begin : g_bank
        int off;
        int col;
        int phys;
        always_comb begin
            off  = srw_pkg::mod_pos(b - x0, MB);
            col  = x0 + off;
            phys = (int'(base_i) + col) % CAP;
            addr_o[b] = ADDR_W'((phys / MB) * WIN_H + y);
        end
    end

endmodule

// File: rtl/srw_fill_ctrl.sv
// Window base pointer and refill progress.
module srw_fill_ctrl #(
    parameter int MB      = 16,
    parameter int H_RANGE = 16,
    parameter int V_RANGE = 8,
    parameter int PCOL_W  = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_ok_i,
    input  logic              adv_i,
    output logic [PCOL_W-1:0] base_o,
    output logic              done_o
);

    localparam int WIN_W      = MB + 2 * H_RANGE;
    localparam int WIN_H      = MB + 2 * V_RANGE;
    localparam int CAP        = WIN_W + MB;
    localparam int FILL_TOTAL = 2 * MB * WIN_H;
    localparam int CNT_W      = $clog2(FILL_TOTAL + 1);

    typedef struct packed {
        logic [PCOL_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
    } fill_st_t;

    localparam fill_st_t FILL_RST = '{base: PCOL_W'(CAP - WIN_W), cnt: '0};

    fill_st_t st_d, st_q;
    logic     done;

    assign done = (st_q.cnt == CNT_W'(FILL_TOTAL));

    always_comb begin
        st_d = st_q;
        if (adv_i && done) begin
            st_d.base = PCOL_W'((int'(st_q.base) + MB) % CAP);
            st_d.cnt  = '0;
        end else if (wr_ok_i && !done) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= FILL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_o = st_q.base;
    assign done_o = done;

endmodule

// File: rtl/srw_window_buffer.sv
// Dual sliding search window with circular column addressing.
module srw_window_buffer #(
    parameter int MB      = 16,
    parameter int PIX_W   = 32,
    parameter int H_RANGE = 16,
    parameter int V_RANGE = 8,
    parameter int MVX_W   = $clog2(H_RANGE + 1) + 1,
    parameter int MVY_W   = $clog2(V_RANGE + 1) + 1
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      wr_en_i,
    input  logic                      wr_frame_i,
    input  logic [$clog2(MB)-1:0]     wr_col_i,
    input  logic [$clog2(MB+2*V_RANGE)-1:0] wr_row_i,
    input  logic [PIX_W-1:0]          wr_data_i,
    input  logic                      mb_adv_i,
    output logic                      fill_done_o,
    input  logic                      rd_en_i,
    input  logic [$clog2(MB)-1:0]     rd_row_i,
    input  logic signed [MVX_W-1:0]   rd_mvx_i,
    input  logic signed [MVY_W-1:0]   rd_mvy_i,
    output logic                      rd_vld_o,
    output logic [MB*PIX_W-1:0]       cur_pix_o,
    output logic [MB*PIX_W-1:0]       ref_pix_o,
    output logic [$clog2(MB)-1:0]     cur_rot_o,
    output logic [$clog2(MB)-1:0]     ref_rot_o
);

    import srw_pkg::*;

    localparam int BANK_W  = $clog2(MB);
    localparam int WIN_W   = MB + 2 * H_RANGE;
    localparam int WIN_H   = MB + 2 * V_RANGE;
    localparam int CAP     = WIN_W + MB;
    localparam int COLS_PB = CAP / MB;
    localparam int DEPTH   = COLS_PB * WIN_H;
    localparam int ADDR_W  = $clog2(DEPTH);
    localparam int PCOL_W  = $clog2(CAP);

    // ---------------- fill control ----------------
    logic              wr_ok;
    logic [PCOL_W-1:0] base_col;

    assign wr_ok = wr_en_i && (int'(wr_row_i) < WIN_H);

    srw_fill_ctrl #(
        .MB(MB), .H_RANGE(H_RANGE), .V_RANGE(V_RANGE), .PCOL_W(PCOL_W)
    ) u_fill (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_ok_i(wr_ok),
        .adv_i  (mb_adv_i),
        .base_o (base_col),
        .done_o (fill_done_o)
    );

    // ---------------- write address ----------------
    int                wr_phys;
    logic [ADDR_W-1:0] wr_addr;

    always_comb begin
        wr_phys = (int'(base_col) + WIN_W + int'(wr_col_i)) % CAP;
        wr_addr = ADDR_W'((wr_phys / MB) * WIN_H + int'(wr_row_i));
    end

    // ---------------- motion vector clamp ----------------
    logic signed [MVX_W-1:0] mvx_cl;
    logic signed [MVY_W-1:0] mvy_cl;

    always_comb begin
        mvx_cl = MVX_W'(clamp_sym(int'(rd_mvx_i), H_RANGE));
        mvy_cl = MVY_W'(clamp_sym(int'(rd_mvy_i), V_RANGE));
    end

    // ---------------- per-frame read address and banks ----------------
    logic [1:0][MB-1:0][ADDR_W-1:0] rd_addr;
    logic [1:0][BANK_W-1:0]         rd_rot;
    logic [1:0][MB-1:0][PIX_W-1:0]  rd_data;

    for (genvar f = 0; f < 2; f++) begin : g_frame
        localparam frame_e FSEL = (f == 0) ? FRAME_CUR : FRAME_REF;
        logic frame_hit;

        assign frame_hit = (frame_e'(wr_frame_i) == FSEL);

        srw_rd_addr #(
            .MB(MB), .H_RANGE(H_RANGE), .V_RANGE(V_RANGE),
            .NEGATE(f == 1), .MVX_W(MVX_W), .MVY_W(MVY_W),
            .PCOL_W(PCOL_W), .ADDR_W(ADDR_W)
        ) u_addr (
            .mvx_i (mvx_cl),
            .mvy_i (mvy_cl),
            .row_i (rd_row_i),
            .base_i(base_col),
            .addr_o(rd_addr[f]),
            .rot_o (rd_rot[f])
        );

        for (genvar b = 0; b < MB; b++) begin : g_bank
            srw_bank #(
                .PIX_W(PIX_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
            ) u_bank (
                .clk_i  (clk_i),
                .we_i   (wr_ok && frame_hit && (wr_col_i == BANK_W'(b))),
                .waddr_i(wr_addr),
                .wdata_i(wr_data_i),
                .re_i   (rd_en_i),
                .raddr_i(rd_addr[f][b]),
                .rdata_o(rd_data[f][b])
            );
        end
    end

    // ---------------- read side pipeline ----------------
    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] cur_rot;
        logic [BANK_W-1:0] ref_rot;
    } rd_st_t;

    rd_st_t rd_d, rd_q;

    always_comb begin
        rd_d     = rd_q;
        rd_d.vld = rd_en_i;
        if (rd_en_i) begin
            rd_d.cur_rot = rd_rot[0];
            rd_d.ref_rot = rd_rot[1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_vld_o  = rd_q.vld;
    assign cur_rot_o = rd_q.cur_rot;
    assign ref_rot_o = rd_q.ref_rot;
    assign cur_pix_o = rd_data[0];
    assign ref_pix_o = rd_data[1];

endmodule

// File: rtl/srw_checker.sv
// Temporal properties of the window buffer, attached by bind.
module srw_checker #(
    parameter int MB      = 16,
    parameter int H_RANGE = 16,
    parameter int PCOL_W  = 6
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic              mb_adv_i,
    input logic              fill_done_o,
    input logic              rd_en_i,
    input logic              rd_vld_o,
    input logic [$clog2(MB)-1:0] cur_rot_o,
    input logic [$clog2(MB)-1:0] ref_rot_o,
    input logic [PCOL_W-1:0] base_col
);

    localparam int CAP = 2 * H_RANGE + 2 * MB;

    assert_vld_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> rd_vld_o);

    assert_vld_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> !rd_vld_o);

    assert_adv_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mb_adv_i && !fill_done_o) |=> $stable(base_col));

    assert_adv_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mb_adv_i && fill_done_o) |=>
            (int'(base_col) == (int'($past(base_col)) + MB) % CAP));

    assert_adv_clears_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mb_adv_i && fill_done_o) |=> !fill_done_o);

    assert_base_aligned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(base_col) % MB) == 0);

    assert_done_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fill_done_o && !mb_adv_i) |=> fill_done_o);

    assert_done_after_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fill_done_o) |-> $past(wr_en_i));

    // Clamping is symmetric, so the two start columns always sum to 2*H_RANGE.
    assert_rot_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_vld_o |-> ((int'(cur_rot_o) + int'(ref_rot_o)) % MB == (2 * H_RANGE) % MB));

endmodule

bind srw_window_buffer srw_checker #(
    .MB(MB), .H_RANGE(H_RANGE), .PCOL_W(PCOL_W)
) i_srw_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .mb_adv_i   (mb_adv_i),
    .fill_done_o(fill_done_o),
    .rd_en_i    (rd_en_i),
    .rd_vld_o   (rd_vld_o),
    .cur_rot_o  (cur_rot_o),
    .ref_rot_o  (ref_rot_o),
    .base_col   (base_col)
);

// File: tb/test_srw_window_buffer.sv
`timescale 1ns/1ps
module test_srw_window_buffer;

    localparam int MB      = 16;
    localparam int PIX_W   = 32;
    localparam int H_RANGE = 16;
    localparam int V_RANGE = 8;
    localparam int MVX_W   = $clog2(H_RANGE + 1) + 1;
    localparam int MVY_W   = $clog2(V_RANGE + 1) + 1;
    localparam int BANK_W  = $clog2(MB);
    localparam int WIN_W   = MB + 2 * H_RANGE;
    localparam int WIN_H   = MB + 2 * V_RANGE;
    localparam int ROW_W   = $clog2(WIN_H);
    localparam int FILL_N  = 2 * MB * WIN_H;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    wr_en = 1'b0;
    logic                    wr_frame = 1'b0;
    logic [BANK_W-1:0]       wr_col = '0;
    logic [ROW_W-1:0]        wr_row = '0;
    logic [PIX_W-1:0]        wr_data = '0;
    logic                    mb_adv = 1'b0;
    logic                    fill_done;
    logic                    rd_en = 1'b0;
    logic [BANK_W-1:0]       rd_row = '0;
    logic signed [MVX_W-1:0] rd_mvx = '0;
    logic signed [MVY_W-1:0] rd_mvy = '0;
    logic                    rd_vld;
    logic [MB*PIX_W-1:0]     cur_pix;
    logic [MB*PIX_W-1:0]     ref_pix;
    logic [BANK_W-1:0]       cur_rot;
    logic [BANK_W-1:0]       ref_rot;

    always #2 clk = ~clk;

    srw_window_buffer #(
        .MB(MB), .PIX_W(PIX_W), .H_RANGE(H_RANGE), .V_RANGE(V_RANGE)
    ) i_srw_window_buffer (
        .clk_i(clk), .rst_ni(rst_n),
        .wr_en_i(wr_en), .wr_frame_i(wr_frame), .wr_col_i(wr_col),
        .wr_row_i(wr_row), .wr_data_i(wr_data),
        .mb_adv_i(mb_adv), .fill_done_o(fill_done),
        .rd_en_i(rd_en), .rd_row_i(rd_row), .rd_mvx_i(rd_mvx), .rd_mvy_i(rd_mvy),
        .rd_vld_o(rd_vld), .cur_pix_o(cur_pix), .ref_pix_o(ref_pix),
        .cur_rot_o(cur_rot), .ref_rot_o(ref_rot)
    );

    typedef struct {
        logic [MB*PIX_W-1:0] cur;
        logic [MB*PIX_W-1:0] rf;
        int                  crot;
        int                  rrot;
        int                  cyc;
        string               tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    int   cyc = 0;
    int   adv_cnt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Pixel content is a function of frame, absolute column and row.
    function automatic logic [PIX_W-1:0] pix(input int f, input int col, input int row);
        return {4'hA, 3'b000, 1'(f), 12'(col), 8'(row), 4'h5};
    endfunction

    function automatic int clampv(input int v, input int lim);
        if (v > lim) return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [MB*PIX_W-1:0] got, input logic [MB*PIX_W-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: got %0h exp %0h", req, what, got, expv);
        end
    endtask

    // Driver: sets the read inputs (caller is at a falling edge) and queues the expectation.
    task automatic push_read(input int row, input int mvx, input int mvy, input string tag);
        exp_t e;
        int   mx, my, left, cx, cy, rx, ry;
        mx   = clampv(mvx, H_RANGE);
        my   = clampv(mvy, V_RANGE);
        left = adv_cnt * MB - WIN_W;
        cx   = H_RANGE + mx;
        cy   = V_RANGE + row + my;
        rx   = H_RANGE - mx;
        ry   = V_RANGE + row - my;
        for (int j = 0; j < MB; j++) begin
            e.cur[j*PIX_W +: PIX_W] = pix(0, left + cx + j, cy);
            e.rf[j*PIX_W +: PIX_W]  = pix(1, left + rx + j, ry);
        end
        e.crot = cx % MB;
        e.rrot = rx % MB;
        e.cyc  = cyc;
        e.tag  = tag;
        exp_q.push_back(e);
        rd_en  = 1'b1;
        rd_row = BANK_W'(row);
        rd_mvx = MVX_W'(mvx);
        rd_mvy = MVY_W'(mvy);
    endtask

    // Monitor: pops one expectation per valid result and compares the aligned view.
    always @(negedge clk) begin
        exp_t                e;
        logic [MB*PIX_W-1:0] act_c;
        logic [MB*PIX_W-1:0] act_r;
        if (rst_n && rd_vld) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected valid", 1, 0);
            end else begin
                e = exp_q.pop_front();
                for (int j = 0; j < MB; j++) begin
                    act_c[j*PIX_W +: PIX_W] = cur_pix[((int'(cur_rot) + j) % MB)*PIX_W +: PIX_W];
                    act_r[j*PIX_W +: PIX_W] = ref_pix[((int'(ref_rot) + j) % MB)*PIX_W +: PIX_W];
                end
                chk(cyc - e.cyc == 1, "R6", {e.tag, " latency"}, cyc - e.cyc, 1);
                chk(int'(cur_rot) == e.crot, "R7", {e.tag, " cur rotation"}, cur_rot, e.crot);
                chk(int'(ref_rot) == e.rrot, "R7", {e.tag, " ref rotation"}, ref_rot, e.rrot);
                chk(act_c == e.cur, "R2", {e.tag, " cur pixels"}, act_c, e.cur);
                chk(act_r == e.rf, "R2", {e.tag, " ref pixels"}, act_r, e.rf);
            end
        end
    end

    task automatic write_strip(input bit with_reads, input bit mid_adv);
        int k;
        int s;
        k = 0;
        s = adv_cnt * MB;
        for (int f = 0; f < 2; f++) begin
            for (int c = 0; c < MB; c++) begin
                for (int r = 0; r < WIN_H; r++) begin
                    if (k == FILL_N - 1)
                        chk(fill_done == 1'b0, "R3", "done before last write", fill_done, 0);
                    if (mid_adv && k == FILL_N / 2 + 1)
                        chk(fill_done == 1'b0, "R4", "early advance kept done low", fill_done, 0);
                    wr_en    = 1'b1;
                    wr_frame = 1'(f);
                    wr_col   = BANK_W'(c);
                    wr_row   = ROW_W'(r);
                    wr_data  = pix(f, s + c, r);
                    mb_adv   = mid_adv && (k == FILL_N / 2);
                    if (with_reads && (k % 4 == 0))
                        push_read(k % MB, (k / 4) % 33 - 16, (k / 8) % 17 - 8, "R9");
                    else
                        rd_en = 1'b0;
                    @(negedge clk);
                    k++;
                end
            end
        end
        wr_en  = 1'b0;
        mb_adv = 1'b0;
        rd_en  = 1'b0;
        chk(fill_done == 1'b1, "R3", "done after last write", fill_done, 1);
    endtask

    task automatic do_adv();
        mb_adv = 1'b1;
        @(negedge clk);
        mb_adv = 1'b0;
        rd_en  = 1'b0;
        adv_cnt++;
        chk(fill_done == 1'b0, "R5", "done cleared by advance", fill_done, 0);
    endtask

    task automatic read_burst(input string tag);
        push_read(0, 0, 0, tag);             @(negedge clk);
        push_read(15, H_RANGE, V_RANGE, tag);  @(negedge clk);
        push_read(7, -H_RANGE, -V_RANGE, tag); @(negedge clk);
        push_read(3, 3, -5, tag);            @(negedge clk);
        push_read(5, -7, 2, tag);            @(negedge clk);
        push_read(2, 31, -16, {tag, " R8"});   @(negedge clk);
        push_read(9, -32, 15, {tag, " R8"});   @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fill_done == 1'b0, "R1", "reset fill_done", fill_done, 0);
        chk(rd_vld == 1'b0, "R1", "reset rd_vld", rd_vld, 0);

        // R4: advance with nothing filled is ignored.
        mb_adv = 1'b1;
        @(negedge clk);
        mb_adv = 1'b0;
        chk(fill_done == 1'b0, "R4", "advance on empty strip", fill_done, 0);

        // R1: initial loading through fill-and-advance steps.
        write_strip(1'b0, 1'b1);
        do_adv();
        write_strip(1'b0, 1'b0);
        do_adv();
        write_strip(1'b0, 1'b0);
        do_adv();

        read_burst("R1 R6");

        // R9: refill of the next strip interleaved with reads of the old window.
        write_strip(1'b1, 1'b0);

        // R10: read issued together with an accepted advance.
        push_read(4, 5, 3, "R10");
        mb_adv = 1'b1;
        @(negedge clk);
        mb_adv = 1'b0;
        rd_en  = 1'b0;
        adv_cnt++;
        chk(fill_done == 1'b0, "R5", "done cleared with read", fill_done, 0);
        @(negedge clk);

        read_burst("R5 R6");
        write_strip(1'b1, 1'b0);
        do_adv();
        read_burst("R5 wrap");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R6", "results outstanding", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R6 watchdog: got %0d cycles exp fewer", cyc);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule